// File: doc/BRIEF.md
# Programmable Watchdog Timer

This peripheral guards a system against software that stops responding. An up-counter starts from a value that software programs and advances on a slow timebase tick. The nominal tick rate is 32 kHz, and an optional prescaler can divide it down. If software lets the counter roll past its all-ones value while the timer is armed, the block raises a one-cycle reset request. It then restarts the count from the programmed value.

Software keeps the timer alive by writing a new value into a kick register. A write changes nothing unless the value differs from what the register already holds. The timer is armed or disarmed only by writing two particular words, in order, to a sequence register. Timebase and preload settings are frozen while the timer is armed.

Each writable register models a write that has to cross into the slow clock domain. For a fixed number of slow ticks after a write, that register shows a busy flag in a status word and refuses further writes. Access is through a single-cycle register port, and read data is registered.

Top module: `wdog_timer`

## Requirements
- R1: After a synchronous reset, the timer is disarmed, the count, preload, timebase and kick registers read zero, the status word reads zero and `wd_reset` is low.
- R2: A read of word address 0 returns `REV_CODE` in bits 7:0 with zeros above. Data for any read appears on `bus_rdata` after the clock edge that samples the read.
- R3: Writing 0x0000BBBB and then 0x00004444 to the sequence register (address 5) arms the timer, and the count then advances.
- R4: Writing 0x0000AAAA and then 0x00005555 to the sequence register disarms the timer, and the count then holds.
- R5: A sequence-register write that is not the expected next word cancels a half-finished sequence. The armed state stays as it was.
- R6: A write to the kick register (address 4) whose value differs from the register's current contents copies the preload register (address 3) into the count register (address 2). Writing the same value again leaves the count alone.
- R7: While armed, the count goes up by one per scaled tick. While disarmed, it only changes through a kick reload.
- R8: In the timebase register (address 1), bit 5 enables the prescaler and bits 4:2 hold P. With the prescaler enabled, the count advances once per 2^P slow ticks. With it disabled, the count advances on every slow tick.
- R9: When an armed timer takes a scaled tick at the all-ones count, `wd_reset` pulses high for exactly one cycle. The count reloads from the preload register and counting carries on.
- R10: While the timer is armed, writes to the timebase and preload registers are dropped and raise no busy flag.
- R11: The status word (address 6) has busy bits at bit 0 (timebase), bit 2 (preload), bit 3 (kick) and bit 4 (sequence). An accepted write sets its bit, and the bit clears on the `PEND_TICKS`-th slow tick after that write.
- R12: A write to a register whose busy bit is set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle enable marking each slow timebase tick |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| wd_reset | output | 1 | One-cycle reset request on overflow |

## Verification
A wrong sequencer state does not show at the ports straight away. It appears as a count that fails to move, or moves when it should not, and the first count read after the next slow tick exposes it. A prescaler divider that is off by one drifts the count by a whole step within 2^P ticks. The bench runs a full model of the count across every prescale setting, so that drift becomes a mismatch at the next read. A wrong busy counter shows up within the ticks of the write that set it, either in the status word or as a write that is lost or accepted when it should not be. A missing or doubled reset pulse is caught at the tick edge where the model predicts the wrap.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // word addresses of the register port
  localparam int unsigned WA_REV   = 0;
  localparam int unsigned WA_CTRL  = 1;
  localparam int unsigned WA_COUNT = 2;
  localparam int unsigned WA_LOAD  = 3;
  localparam int unsigned WA_KICK  = 4;
  localparam int unsigned WA_SEQ   = 5;
  localparam int unsigned WA_STAT  = 6;

  // sequence-register key words
  localparam logic [31:0] KEY_ARM_A = 32'h0000_BBBB;
  localparam logic [31:0] KEY_ARM_B = 32'h0000_4444;
  localparam logic [31:0] KEY_DIS_A = 32'h0000_AAAA;
  localparam logic [31:0] KEY_DIS_B = 32'h0000_5555;

  // timebase register fields
  localparam int unsigned PRE_EN_BIT = 5;
  localparam int unsigned PRE_P_LSB  = 2;

  // busy-flag index and status bit position
  localparam int unsigned NUM_BUSY = 4;
  localparam int unsigned BI_CTRL  = 0;
  localparam int unsigned BI_LOAD  = 1;
  localparam int unsigned BI_KICK  = 2;
  localparam int unsigned BI_SEQ   = 3;

  function automatic int unsigned busy_addr(input int unsigned idx);
    case (idx)
      BI_CTRL: busy_addr = WA_CTRL;
      BI_LOAD: busy_addr = WA_LOAD;
      BI_KICK: busy_addr = WA_KICK;
      default: busy_addr = WA_SEQ;
    endcase
  endfunction

  function automatic int unsigned busy_stat_bit(input int unsigned idx);
    case (idx)
      BI_CTRL: busy_stat_bit = 0;
      BI_LOAD: busy_stat_bit = 2;
      BI_KICK: busy_stat_bit = 3;
      default: busy_stat_bit = 4;
    endcase
  endfunction

  typedef enum logic [1:0] {
    SEQ_IDLE     = 2'd0,
    SEQ_ARM_HALF = 2'd1,
    SEQ_DIS_HALF = 2'd2
  } seq_state_t;
endpackage

// File: rtl/wdt_busy_flag.sv
module wdt_busy_flag #(
  parameter int PEND_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic slow_tick,
  output logic busy
);
  localparam int PW = $clog2(PEND_TICKS + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)
      left_q <= '0;
    else if (start)
      left_q <= PW'(PEND_TICKS);
    else if (slow_tick && left_q != '0)
      left_q <= left_q - PW'(1);
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              armed
);
  seq_state_t st_q;

  logic is_arm_a, is_arm_b, is_dis_a, is_dis_b;
  assign is_arm_a = (wr_data == DATA_W'(KEY_ARM_A));
  assign is_arm_b = (wr_data == DATA_W'(KEY_ARM_B));
  assign is_dis_a = (wr_data == DATA_W'(KEY_DIS_A));
  assign is_dis_b = (wr_data == DATA_W'(KEY_DIS_B));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SEQ_IDLE;
      armed <= 1'b0;
    end else if (wr_en) begin
      if (is_arm_a)
        st_q <= SEQ_ARM_HALF;
      else if (is_dis_a)
        st_q <= SEQ_DIS_HALF;
      else begin
        st_q <= SEQ_IDLE;
        if (st_q == SEQ_ARM_HALF && is_arm_b) armed <= 1'b1;
        if (st_q == SEQ_DIS_HALF && is_dis_b) armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            slow_tick,
  input  logic            pre_en,
  input  logic [PS_W-1:0] pre_p,
  output logic            step_en
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] lim;

  assign span = (DIV_W + 1)'(1) << pre_p;
  assign lim  = DIV_W'(span - (DIV_W + 1)'(1));

  assign step_en = run && slow_tick && (!pre_en || div_q == lim);

  always_ff @(posedge clk) begin
    if (rst || !run)
      div_q <= '0;
    else if (slow_tick && pre_en)
      div_q <= (div_q == lim) ? '0 : div_q + DIV_W'(1);
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdt_pkg::*;
#(
  parameter int           ADDR_W     = 3,
  parameter int           DATA_W     = 32,
  parameter int           CNT_W      = 32,
  parameter int           PS_W       = 3,
  parameter int           PEND_TICKS = 2,
  parameter logic [7:0]   REV_CODE   = 8'h31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wd_reset
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic              pre_en_q;
  logic [PS_W-1:0]   pre_p_q;
  logic [CNT_W-1:0]  load_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] kick_q;
  logic              run_q;
  logic              step_en;
  logic              reload;
  logic [NUM_BUSY-1:0] busy_vec;
  logic [NUM_BUSY-1:0] wr_acc;
  logic [DATA_W-1:0]   stat_word;

  // write decode, busy flags and status bits, one per writable register
  for (genvar gi = 0; gi < NUM_BUSY; gi++) begin : g_busy
    localparam bit LOCKS = (gi == BI_CTRL) || (gi == BI_LOAD);
    logic hit;
    assign hit = bus_sel && bus_we && (bus_addr == ADDR_W'(busy_addr(gi)));
    assign wr_acc[gi] = hit && !busy_vec[gi] && !(LOCKS && run_q);

    wdt_busy_flag #(.PEND_TICKS(PEND_TICKS)) u_flag (
      .clk      (clk),
      .rst      (rst),
      .start    (wr_acc[gi]),
      .slow_tick(slow_tick),
      .busy     (busy_vec[gi])
    );
  end

  always_comb begin
    stat_word = '0;
    for (int i = 0; i < NUM_BUSY; i++)
      stat_word[busy_stat_bit(i)] = busy_vec[i];
  end

  wdt_key_seq #(.DATA_W(DATA_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_acc[BI_SEQ]),
    .wr_data(bus_wdata),
    .armed  (run_q)
  );

  wdt_prescale #(.PS_W(PS_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .run      (run_q),
    .slow_tick(slow_tick),
    .pre_en   (pre_en_q),
    .pre_p    (pre_p_q),
    .step_en  (step_en)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pre_en_q <= 1'b0;
      pre_p_q  <= '0;
      load_q   <= '0;
      kick_q   <= '0;
    end else begin
      if (wr_acc[BI_CTRL]) begin
        pre_en_q <= bus_wdata[PRE_EN_BIT];
        pre_p_q  <= bus_wdata[PRE_P_LSB +: PS_W];
      end
      if (wr_acc[BI_LOAD]) load_q <= bus_wdata[CNT_W-1:0];
      if (wr_acc[BI_KICK]) kick_q <= bus_wdata;
    end
  end

  assign reload = wr_acc[BI_KICK] && (bus_wdata != kick_q);

  // counter and reset request
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      wd_reset <= 1'b0;
    end else begin
      wd_reset <= 1'b0;
      if (reload)
        cnt_q <= load_q;
      else if (step_en) begin
        if (cnt_q == CNT_TOP) begin
          cnt_q    <= load_q;
          wd_reset <= 1'b1;
        end else
          cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_sel && !bus_we) begin
      bus_rdata <= '0;
      case (bus_addr)
        ADDR_W'(WA_REV):   bus_rdata <= DATA_W'(REV_CODE);
        ADDR_W'(WA_CTRL): begin
          bus_rdata[PRE_EN_BIT]          <= pre_en_q;
          bus_rdata[PRE_P_LSB +: PS_W]   <= pre_p_q;
        end
        ADDR_W'(WA_COUNT): bus_rdata <= DATA_W'(cnt_q);
        ADDR_W'(WA_LOAD):  bus_rdata <= DATA_W'(load_q);
        ADDR_W'(WA_KICK):  bus_rdata <= kick_q;
        ADDR_W'(WA_SEQ):   bus_rdata <= DATA_W'(run_q);
        ADDR_W'(WA_STAT):  bus_rdata <= stat_word;
        default:           bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              run_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  load_q,
  input logic [NUM_BUSY-1:0] busy_vec,
  input logic              wd_reset
);
  logic kick_wr, load_wr;
  assign kick_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(WA_KICK));
  assign load_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(WA_LOAD));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cnt_q == '0 && !run_q && busy_vec == '0 && !wd_reset));

  // R9
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    wd_reset |=> !wd_reset);

  // R9
  wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
    wd_reset |-> (cnt_q == load_q && $past(run_q)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !kick_wr) |=> $stable(cnt_q));

  // R10
  load_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && load_wr) |=> $stable(load_q));

  // R11
  busy_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_vec[BI_LOAD]) |-> $past(load_wr));
endmodule

bind wdog_timer wdog_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_sel (bus_sel),
  .bus_we  (bus_we),
  .bus_addr(bus_addr),
  .run_q   (run_q),
  .cnt_q   (cnt_q),
  .load_q  (load_q),
  .busy_vec(busy_vec),
  .wd_reset(wd_reset)
);

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
  localparam int         CNT_W = 8;
  localparam logic [7:0] REV   = 8'h31;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wd_reset;

  int n_chk = 0;
  int n_fail = 0;

  // bench model
  bit          m_run = 0;
  bit          m_pen = 0;
  int          m_p = 0;
  int          m_pre = 0;
  int          m_cnt = 0;
  int          m_load = 0;
  logic [31:0] m_kick = '0;
  int          m_wraps = 0;

  wdog_timer #(.CNT_W(CNT_W), .PEND_TICKS(2), .REV_CODE(REV)) u0 (
    .clk(clk), .rst(rst), .slow_tick(slow_tick),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_reset(wd_reset)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      bit exp_wrap = 0;
      if (m_run) begin
        if (!m_pen || m_pre == (1 << m_p) - 1) begin
          m_pre = 0;
          if (m_cnt == (1 << CNT_W) - 1) begin
            m_cnt = m_load; exp_wrap = 1; m_wraps++;
          end else m_cnt++;
        end else m_pre++;
      end
      slow_tick = 1;
      @(posedge clk); #1;
      slow_tick = 0;
      if (exp_wrap || wd_reset) chk("R9 pulse on wrap", 32'(wd_reset), 32'(exp_wrap));
      @(posedge clk); #1;
      if (exp_wrap) chk("R9 single-cycle pulse", 32'(wd_reset), 0);
    end
  endtask

  task automatic arm();
    wr(5, 32'h0000BBBB); tick(2);
    wr(5, 32'h00004444); m_run = 1; m_pre = 0; tick(2);
  endtask

  task automatic disarm();
    wr(5, 32'h0000AAAA); tick(2);
    wr(5, 32'h00005555); m_run = 0; m_pre = 0; tick(2);
  endtask

  task automatic kick(input logic [31:0] v);
    wr(4, v);
    if (v != m_kick) m_cnt = m_load;
    m_kick = v;
    tick(2);
  endtask

  task automatic chk_cnt(input string tag);
    logic [31:0] d;
    rd(2, d);
    chk(tag, d, 32'(m_cnt));
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(posedge clk); #1;

    // R1 reset state
    rd(2, d); chk("R1 count", d, 0);
    rd(3, d); chk("R1 preload", d, 0);
    rd(1, d); chk("R1 timebase", d, 0);
    rd(6, d); chk("R1 status", d, 0);
    rd(5, d); chk("R1 disarmed", d, 0);
    chk("R1 wd_reset", 32'(wd_reset), 0);

    // R2 revision
    rd(0, d); chk("R2 revision", d, 32'(REV));

    // R11 / R12 busy flag on preload
    wr(3, 32'hF0);
    rd(6, d); chk("R11 preload busy bit2", d, 32'h04);
    wr(3, 32'h11);
    tick(1);
    rd(6, d); chk("R11 still busy after 1 tick", d, 32'h04);
    tick(1);
    rd(6, d); chk("R11 clear after 2 ticks", d, 0);
    rd(3, d); chk("R12 busy write ignored", d, 32'hF0);
    m_load = 'hF0;

    // R8 timebase: prescaler on, P=1
    wr(1, 32'h24);
    rd(6, d); chk("R11 timebase busy bit0", d, 32'h01);
    tick(2); m_pen = 1; m_p = 1;
    rd(1, d); chk("R8 timebase readback", d, 32'h24);

    // R3 arm, R7 count
    arm();
    rd(5, d); chk("R3 armed", d, 1);
    tick(4);
    chk_cnt("R3 R7 count advances");

    // R6 kick with change reloads, same value does not
    wr(4, 32'h1);
    rd(6, d); chk("R11 kick busy bit3", d, 32'h08);
    m_cnt = m_load; m_kick = 1; tick(2);
    chk_cnt("R6 reload on changed kick");
    tick(3);
    kick(32'h1);
    chk_cnt("R6 same kick no reload");

    // R10 locked writes while armed
    wr(3, 32'h00);
    rd(6, d); chk("R10 no busy on locked write", d, 0);
    rd(3, d); chk("R10 preload unchanged", d, 32'hF0);
    wr(1, 32'h00);
    rd(1, d); chk("R10 timebase unchanged", d, 32'h24);

    // R9 overflow and wrap
    tick(80);
    chk("R9 wraps seen", 32'(m_wraps > 0), 1);
    chk_cnt("R9 count after wraps");

    // R5 cancelled disarm
    wr(5, 32'h0000AAAA); tick(2);
    wr(5, 32'h00001234); tick(2);
    wr(5, 32'h00005555); tick(2);
    rd(5, d); chk("R5 cancelled disarm stays armed", d, 1);
    chk_cnt("R5 count after cancel");

    // R12 sequence write while busy
    wr(5, 32'h0000AAAA);
    rd(6, d); chk("R11 sequence busy bit4", d, 32'h10);
    wr(5, 32'h00005555);
    tick(2);
    rd(5, d); chk("R12 busy sequence write ignored", d, 1);
    wr(5, 32'h00005555); m_run = 0; m_pre = 0; tick(2);

    // R4 disarmed holds
    rd(5, d); chk("R4 disarmed", d, 0);
    chk_cnt("R4 count at disarm");
    tick(9);
    chk_cnt("R4 R7 count holds");

    // R5 cancelled arm
    wr(5, 32'h0000BBBB); tick(2);
    wr(5, 32'h00000000); tick(2);
    wr(5, 32'h00004444); tick(2);
    rd(5, d); chk("R5 cancelled arm stays disarmed", d, 0);
    tick(4);
    chk_cnt("R5 no counting");

    // R8 sweep over prescale settings
    for (int en = 0; en < 2; en++) begin
      for (int p = 0; p < 8; p++) begin
        if (en == 0 && p > 0) continue;
        wr(1, 32'((en << 5) | (p << 2))); tick(2);
        m_pen = en[0]; m_p = p;
        wr(3, 32'h10 + 32'(p)); tick(2); m_load = 'h10 + p;
        kick(m_kick + 1);
        arm();
        tick(3 + 5 * p);
        chk_cnt($sformatf("R8 en=%0d P=%0d", en, p));
        disarm();
        chk_cnt($sformatf("R7 R8 held en=%0d P=%0d", en, p));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule